// File: doc/BRIEF.md
# AES Half-Round Datapath

This block performs one AES round step on half of the 128-bit AES state. The state arrives split across two 64-bit operands: `src_a` carries state bytes 0 to 7 and `src_b` carries bytes 8 to 15, byte 0 in bits 7:0. The block gathers the eight bytes that land in the low half of the state after row shifting, and passes each through the S-box. It can then mix the two 32-bit columns of that half. A direction input picks the forward or the inverse form of all three steps. No round key is ever added.

The caller obtains the upper half of the state by issuing the same operation again with the two operands swapped. Operations enter through a valid/ready pair. The 64-bit result is registered and is presented on a second valid/ready pair in the cycle after the operation is accepted.

The controller has two states. `ST_EMPTY` holds no result. `ST_FULL` holds a result that has not yet been taken. The transitions are as follows:
- `ST_EMPTY`→`ST_FULL` on accept.
- `ST_FULL`→`ST_EMPTY` when the result is taken and no new operation is accepted.
- `ST_FULL`→`ST_FULL` when the result is taken and a new operation is accepted in the same cycle, or when the result is not taken.

Top module: `aes_hr_unit`

## Requirements
- R1: In forward mode, output byte positions 0..7, before substitution, come from a0, a5, b2, b7, a4, b1, b6 and a3 respectively. Here aN is byte N of `src_a` and bN is byte N of `src_b`, and byte N is bits 8N+7:8N.
- R2: In forward mode (`in_decrypt`=0), every gathered byte passes through the AES forward S-box, for example 0x00→0x63 and 0x53→0xED.
- R3: In inverse mode, output byte positions 0..7, before substitution, come from a0, b5, b2, a7, a4, a1, b6 and b3 respectively.
- R4: In inverse mode (`in_decrypt`=1), every gathered byte passes through the inverse S-box, which exactly undoes the forward one (0x63→0x00).
- R5: With `in_mix`=0, the substituted 64-bit value is the result unchanged. No key is XORed in either mode.
- R6: With `in_mix`=1 in forward mode, bits 31:0 and bits 63:32 are mixed as separate columns. Within a column, output byte i = 2·c[i] ^ 3·c[i+1] ^ c[i+2] ^ c[i+3], with indices mod 4 and products in GF(2^8) modulo 0x11B.
- R7: With `in_mix`=1 in inverse mode, output byte i = 0x0E·c[i] ^ 0x0B·c[i+1] ^ 0x0D·c[i+2] ^ 0x09·c[i+3] within each column.
- R8: An operation is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when no result is held or when the held result is taken in that cycle. `out_valid` is high in the cycle after an accept.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` stay unchanged, and `in_ready` is low.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: Take lo = forward-no-mix(a,b) and hi = forward-no-mix(b,a). Then inverse-no-mix(lo,hi) returns a, and inverse-no-mix(hi,lo) returns b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_decrypt | input | 1 | 1 selects the inverse steps |
| in_mix | input | 1 | 1 enables column mixing |
| in_src_a | input | 64 | State bytes 0..7 (or 8..15 when swapped) |
| in_src_b | input | 64 | State bytes 8..15 (or 0..7 when swapped) |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken |
| out_data | output | 64 | Half-state result |

## Verification
The hardest case to reach from the ports is `ST_FULL`→`ST_FULL` under backpressure. Here a second operation waits at the input while the first result is held, and the hand-over must be clean. The bench holds `out_ready` low, issues one operation, and then offers a second one for several cycles. It checks that the input is refused and the first result does not move. It then raises `out_ready` and checks that the held result is released and the waiting operation is loaded on the same edge. Byte routing is exposed with operands whose bytes are all distinct, and inverse correctness is shown by a round trip over both halves of the state.

// File: rtl/aes_hr_pkg.sv
package aes_hr_pkg;
    localparam int HALF_W    = 64;
    localparam int BYTE_W    = 8;
    localparam int N_BYTES   = HALF_W / BYTE_W;
    localparam int COL_BYTES = 4;
    localparam int N_COLS    = N_BYTES / COL_BYTES;
    localparam int SEL_W     = $clog2(N_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hr_state_t;

    function automatic byte_t xtime(byte_t v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gmul(byte_t x, byte_t y);
        byte_t acc;
        byte_t p;
        acc = '0;
        p   = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // x^254 by square-and-multiply; maps 0 to 0
    function automatic byte_t ginv(byte_t x);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = x;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(byte_t v, int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_fwd(byte_t x);
        byte_t q;
        q = ginv(x);
        return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
    endfunction

    function automatic byte_t sbox_inv(byte_t s);
        byte_t q;
        q = rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
        return ginv(q);
    endfunction

    // {from_b, byte index} for each output lane, forward direction
    function automatic logic [SEL_W:0] pick_fwd(int lane);
        case (lane)
            0: return {1'b0, 3'd0};
            1: return {1'b0, 3'd5};
            2: return {1'b1, 3'd2};
            3: return {1'b1, 3'd7};
            4: return {1'b0, 3'd4};
            5: return {1'b1, 3'd1};
            6: return {1'b1, 3'd6};
            default: return {1'b0, 3'd3};
        endcase
    endfunction

    function automatic logic [SEL_W:0] pick_inv(int lane);
        case (lane)
            0: return {1'b0, 3'd0};
            1: return {1'b1, 3'd5};
            2: return {1'b1, 3'd2};
            3: return {1'b0, 3'd7};
            4: return {1'b0, 3'd4};
            5: return {1'b0, 3'd1};
            6: return {1'b1, 3'd6};
            default: return {1'b1, 3'd3};
        endcase
    endfunction

    function automatic byte_t mix_coef(logic inverse, int k);
        case (k)
            0: return inverse ? 8'h0e : 8'h02;
            1: return inverse ? 8'h0b : 8'h03;
            2: return inverse ? 8'h0d : 8'h01;
            default: return inverse ? 8'h09 : 8'h01;
        endcase
    endfunction
endpackage

// File: rtl/aes_hr_gather.sv
module aes_hr_gather
    import aes_hr_pkg::*;
(
    input  logic              decrypt,
    input  logic [HALF_W-1:0] src_a,
    input  logic [HALF_W-1:0] src_b,
    output logic [HALF_W-1:0] picked
);
    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        localparam logic [SEL_W:0] FSEL = pick_fwd(g);
        localparam logic [SEL_W:0] ISEL = pick_inv(g);
        byte_t f_byte;
        byte_t i_byte;
        assign f_byte = FSEL[SEL_W] ? src_b[FSEL[SEL_W-1:0]*BYTE_W +: BYTE_W]
                                    : src_a[FSEL[SEL_W-1:0]*BYTE_W +: BYTE_W];
        assign i_byte = ISEL[SEL_W] ? src_b[ISEL[SEL_W-1:0]*BYTE_W +: BYTE_W]
                                    : src_a[ISEL[SEL_W-1:0]*BYTE_W +: BYTE_W];
        assign picked[g*BYTE_W +: BYTE_W] = decrypt ? i_byte : f_byte;
    end
endmodule

// File: rtl/aes_hr_subst.sv
module aes_hr_subst
    import aes_hr_pkg::*;
(
    input  logic              decrypt,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] dout
);
    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        byte_t x;
        byte_t y;
        assign x = din[g*BYTE_W +: BYTE_W];
        always_comb begin
            if (decrypt) y = sbox_inv(x);
            else         y = sbox_fwd(x);
        end
        assign dout[g*BYTE_W +: BYTE_W] = y;
    end
endmodule

// File: rtl/aes_hr_mix.sv
module aes_hr_mix
    import aes_hr_pkg::*;
(
    input  logic              decrypt,
    input  logic [HALF_W-1:0] din,
    output logic [HALF_W-1:0] dout
);
    localparam int COL_W = COL_BYTES * BYTE_W;

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        logic [COL_W-1:0] col_in;
        logic [COL_W-1:0] col_out;
        assign col_in = din[c*COL_W +: COL_W];
        for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
            byte_t acc;
            always_comb begin
                acc = '0;
                for (int k = 0; k < COL_BYTES; k++) begin
                    acc = acc ^ gmul(col_in[((i + k) % COL_BYTES)*BYTE_W +: BYTE_W],
                                     mix_coef(decrypt, k));
                end
            end
            assign col_out[i*BYTE_W +: BYTE_W] = acc;
        end
        assign dout[c*COL_W +: COL_W] = col_out;
    end
endmodule

// File: rtl/aes_hr_unit.sv
module aes_hr_unit
    import aes_hr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_decrypt,
    input  logic              in_mix,
    input  logic [HALF_W-1:0] in_src_a,
    input  logic [HALF_W-1:0] in_src_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HALF_W-1:0] out_data
);
    hr_state_t         state_q, state_d;
    logic [HALF_W-1:0] picked, subbed, mixed, result;
    logic [HALF_W-1:0] data_q;
    logic              accept;

    aes_hr_gather u_gather (.decrypt(in_decrypt), .src_a(in_src_a), .src_b(in_src_b), .picked(picked));
    aes_hr_subst  u_subst  (.decrypt(in_decrypt), .din(picked), .dout(subbed));
    aes_hr_mix    u_mix    (.decrypt(in_decrypt), .din(subbed), .dout(mixed));

    assign result = in_mix ? mixed : subbed;
    assign accept = in_valid && in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= result;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
            end
        endcase
    end
    assign out_data = data_q;

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/aes_hr_unit_tb_top.sv
module aes_hr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_decrypt = 1'b0;
    logic        in_mix = 1'b0;
    logic [63:0] in_src_a = '0;
    logic [63:0] in_src_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    aes_hr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_decrypt(in_decrypt), .in_mix(in_mix), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // ---- independent reference ----
    function automatic logic [7:0] m_mul(logic [7:0] x, logic [7:0] y);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (y[i]) prod ^= 16'(x) << i;
        for (int i = 15; i >= 8; i--) if (prod[i]) prod ^= 16'h11b << (i - 8);
        return prod[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(logic [7:0] x);
        logic [7:0] q = 8'h00;
        logic [7:0] s;
        for (int c = 1; c < 256; c++) if (m_mul(x, 8'(c)) == 8'h01) q = 8'(c);
        for (int i = 0; i < 8; i++)
            s[i] = q[i] ^ q[(i+4)%8] ^ q[(i+5)%8] ^ q[(i+6)%8] ^ q[(i+7)%8];
        return s ^ 8'h63;
    endfunction

    function automatic logic [7:0] m_isbox(logic [7:0] v);
        logic [7:0] r = 8'h00;
        for (int c = 0; c < 256; c++) if (m_sbox(8'(c)) == v) r = 8'(c);
        return r;
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, bit dec, bit mix);
        int fsrc[8] = '{0, 5, 10, 15, 4, 9, 14, 3};   // 0..7 from a, 8..15 from b
        int isrc[8] = '{0, 13, 10, 7, 4, 1, 14, 11};
        logic [127:0] st = {b, a};
        logic [7:0] t[8];
        logic [7:0] cf[4];
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            t[i] = st[(dec ? isrc[i] : fsrc[i])*8 +: 8];
            t[i] = dec ? m_isbox(t[i]) : m_sbox(t[i]);
        end
        cf = dec ? '{8'h0e, 8'h0b, 8'h0d, 8'h09} : '{8'h02, 8'h03, 8'h01, 8'h01};
        for (int i = 0; i < 8; i++) begin
            int base = (i / 4) * 4;
            logic [7:0] acc = 8'h00;
            for (int k = 0; k < 4; k++) acc ^= m_mul(t[base + (i%4 + k)%4], cf[k]);
            r[i*8 +: 8] = mix ? acc : t[i];
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one operation with out_ready high; result sampled after the accepting edge
    task automatic run_op(logic [63:0] a, logic [63:0] b, bit dec, bit mix, output logic [63:0] res);
        @(negedge clk);
        in_src_a = a; in_src_b = b; in_decrypt = dec; in_mix = mix; in_valid = 1'b1;
        @(posedge clk); #1;
        check("R8 out_valid after accept", {63'd0, out_valid}, 64'd1);
        res = out_data;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 out_valid", {63'd0, out_valid}, 64'd0);
        check("R10 in_ready", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_fips;
        logic [63:0] a = 64'h2be2f4a0bee33d19, b = 64'h0848f8e92a8dc69a, r;
        run_op(a, b, 0, 0, r);
        check("R1/R2/R5 forward no-mix known round", r, 64'hae52b4e0305dbfd4);
        run_op(a, b, 0, 1, r);
        check("R6 forward mix known round", r, 64'h9a19cbe0e5816604);
    endtask

    task automatic t_sbox_points;
        logic [63:0] r;
        run_op({8{8'h53}}, {8{8'h53}}, 0, 0, r);
        check("R2 sbox 53->ED", r, {8{8'hed}});
        run_op({8{8'h63}}, {8{8'h63}}, 1, 0, r);
        check("R4 inverse sbox 63->00", r, 64'd0);
        run_op(64'd0, 64'd0, 0, 0, r);
        check("R5 zero input, no key", r, {8{8'h63}});
    endtask

    task automatic t_routing;
        logic [63:0] a = 64'h0706050403020100, b = 64'h8f8e8d8c8b8a8988, r;
        run_op(a, b, 0, 0, r);
        check("R1 forward byte routing", r, model(a, b, 0, 0));
        run_op(a, b, 1, 0, r);
        check("R3 inverse byte routing", r, model(a, b, 1, 0));
        run_op(a, b, 1, 1, r);
        check("R7 inverse mix", r, model(a, b, 1, 1));
        run_op(64'hdeadbeef01234567, 64'h89abcdeffedcba98, 1, 1, r);
        check("R7 inverse mix pattern 2", r, model(64'hdeadbeef01234567, 64'h89abcdeffedcba98, 1, 1));
        run_op(64'hdeadbeef01234567, 64'h89abcdeffedcba98, 0, 1, r);
        check("R6 forward mix pattern 2", r, model(64'hdeadbeef01234567, 64'h89abcdeffedcba98, 0, 1));
    endtask

    task automatic t_roundtrip;
        logic [63:0] a = 64'h0123456789abcdef, b = 64'hf0e1d2c3b4a59687, lo, hi, r;
        run_op(a, b, 0, 0, lo);
        run_op(b, a, 0, 0, hi);
        run_op(lo, hi, 1, 0, r);
        check("R11 round trip low half", r, a);
        run_op(hi, lo, 1, 0, r);
        check("R11 round trip high half", r, b);
    endtask

    task automatic t_backpressure;
        logic [63:0] e1 = model(64'h1111, 64'h2222, 0, 1);
        logic [63:0] e2 = model(64'h3333, 64'h4444, 1, 0);
        @(negedge clk);
        out_ready = 1'b0;
        in_src_a = 64'h1111; in_src_b = 64'h2222; in_decrypt = 0; in_mix = 1; in_valid = 1'b1;
        @(negedge clk);
        in_src_a = 64'h3333; in_src_b = 64'h4444; in_decrypt = 1; in_mix = 0;
        check("R9 in_ready low while held", {63'd0, in_ready}, 64'd0);
        repeat (3) @(negedge clk);
        check("R9 held valid", {63'd0, out_valid}, 64'd1);
        check("R9 held data", out_data, e1);
        out_ready = 1'b1;
        #1;
        check("R8 in_ready when result taken", {63'd0, in_ready}, 64'd1);
        @(posedge clk); #1;
        check("R8 back-to-back load", out_data, e2);
        check("R8 still valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R8 drained", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fips;
        t_sbox_points;
        t_routing;
        t_roundtrip;
        t_backpressure;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule